// File: doc/BRIEF.md
# Timer Interrupt Culling Controller

This block sits next to an up/down PWM timer counter and thins out two of its event streams: the counter-zero event and compare channel 3. One 3-bit field sets how many of these events make up one interrupt (every event, or one in 2, 4, 8 or 16). The other compare channels pass through unchanged. The same cull decision also gates the strobe that copies buffer registers into the compare registers. As a result, PWM duty updates happen only at the interrupt points software actually services, unless a mask-transfer enable asks for a reload on every raw event.

The block also divides the count clock for the timer. A 3-bit field selects division by 1 to 32, and the block emits a single-cycle count-enable tick. A newly written culling ratio takes effect only after the next interrupt at the old ratio. A newly written prescaler ratio is taken up only on a raw counter-zero event, and that includes zero events that are culled. While the run enable is low, all counting state is cleared and both ratio fields load directly.

Top module: `intr_cull_ctrl`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `run` low, every output is 0. While `run` is low, the cull counters and the clock divider are cleared, and the cull ratio loads directly from `cull_sel`.
- R2: The `cull_sel` code values map to ratios as follows: 0 passes every event; 1, 2, 3 and 4 pass every 2nd, 4th, 8th and 16th event; codes 5 to 7 pass every 16th event. The passing event is the Nth one counted since `run` rose or since the last pass.
- R3: The counter-zero stream and compare channel 3 (bit 3 of `cmp_evt`) each keep their own event count, and both use the ratio from `cull_sel`.
- R4: Compare bits 0, 1, 2, 4 and 5 are never culled. Each event appears on the matching `cmp_irq` bit.
- R5: A `cull_sel` value written while `run` is high is applied only after the next pass of that stream at the old ratio.
- R6: With `xfer_all` = 0, `reload` fires for a counter-zero event only when `xfer_zero_en` = 1 and that event passes the cull. It fires for a compare-3 event only when `xfer_cmp_en` = 1 and that event passes the cull.
- R7: With `xfer_all` = 1, `reload` fires on every raw event whose transfer enable is set, whether or not the event was culled.
- R8: `pre_sel` codes 0 to 5 give one `cnt_tick` every 1, 2, 4, 8, 16 or 32 cycles while running.
- R9: While `run` is high, a new `pre_sel` value is taken up only in a cycle with a raw counter-zero event, whether that event is culled or not. If the divider count is already at or above the new limit, the next tick is immediate.
- R10: `pre_sel` codes 6 and 7 are prohibited: they leave the current division ratio unchanged, both at idle and at a zero event.
- R11: Every output is a registered single-cycle pulse. It appears in the cycle after the input event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Run enable; low clears counters |
| zero_evt | input | 1 | Raw counter-zero event pulse |
| cmp_evt | input | 6 | Raw compare-match event pulses |
| cull_sel | input | 3 | Culling ratio code |
| pre_sel | input | 3 | Prescaler ratio code |
| xfer_zero_en | input | 1 | Allow reload on counter-zero events |
| xfer_cmp_en | input | 1 | Allow reload on compare-3 events |
| xfer_all | input | 1 | Reload on every raw event, ignoring culling |
| zero_irq | output | 1 | Culled counter-zero interrupt |
| cmp_irq | output | 6 | Compare interrupts, bit 3 culled |
| reload | output | 1 | Buffer-to-compare reload strobe |
| cnt_tick | output | 1 | Count-enable tick for the timer |

## Verification
Each of the eight cull codes is run with a dense train of zero and compare-3 events, and the pulse totals are counted. This separates the ratio mapping and shows that codes above 4 saturate at 1/16. The following patterns are also applied:
- Interleaved zero and compare-3 trains show whether the two streams keep separate counts.
- A ratio change part way through a train shows whether the old ratio finishes first.
- Reload trains with the mask-transfer enable off and on show whether the reload follows culled or raw events.
- Prescaler runs at each code, changes written without a zero event, and changes written with a culled zero event or a prohibited code show where the divider ratio is allowed to switch.
- A long pseudo-random stretch with configuration changes is compared cycle by cycle against a reference model.

// File: rtl/intr_cull_ctrl.sv
module intr_cull_ctrl #(
  parameter int CMP_N    = 6,
  parameter int CULL_CMP = 3,
  parameter int CULL_W   = 4,
  parameter int PRE_MAX  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             zero_evt,
  input  logic [CMP_N-1:0] cmp_evt,
  input  logic [2:0]       cull_sel,
  input  logic [2:0]       pre_sel,
  input  logic             xfer_zero_en,
  input  logic             xfer_cmp_en,
  input  logic             xfer_all,
  output logic             zero_irq,
  output logic [CMP_N-1:0] cmp_irq,
  output logic             reload,
  output logic             cnt_tick
);
  localparam int DIV_W = PRE_MAX;

  function automatic logic [CULL_W-1:0] cull_lim(input logic [2:0] c);
    int k;
    k = (int'(c) > CULL_W) ? CULL_W : int'(c);
    return CULL_W'((1 << k) - 1);
  endfunction

  logic [1:0] lane_evt, lane_pass;
  assign lane_evt = {cmp_evt[CULL_CMP], zero_evt};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [CULL_W-1:0] cnt, lim;
    assign lane_pass[g] = run && lane_evt[g] && (cnt == lim);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        lim <= '0;
      end else if (!run) begin
        cnt <= '0;
        lim <= cull_lim(cull_sel);
      end else if (lane_evt[g]) begin
        if (cnt == lim) begin
          cnt <= '0;
          lim <= cull_lim(cull_sel);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
  end

  logic [DIV_W-1:0] div_cnt, div_lim;
  logic [2:0]       pre_act;
  logic             pre_ok, tick;

  assign pre_ok  = pre_sel <= 3'(PRE_MAX);
  assign div_lim = DIV_W'((1 << pre_act) - 1);
  assign tick    = run && (div_cnt >= div_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      pre_act <= '0;
    end else if (!run) begin
      div_cnt <= '0;
      if (pre_ok) pre_act <= pre_sel;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (zero_evt && pre_ok) pre_act <= pre_sel;
    end

  logic [CMP_N-1:0] cmp_d;
  for (genvar i = 0; i < CMP_N; i++) begin : g_cmp
    if (i == CULL_CMP) begin : g_cull
      assign cmp_d[i] = lane_pass[1];
    end else begin : g_raw
      assign cmp_d[i] = run & cmp_evt[i];
    end
  end

  logic reload_d;
  assign reload_d = run &
    ((xfer_zero_en & (xfer_all ? zero_evt : lane_pass[0])) |
     (xfer_cmp_en  & (xfer_all ? cmp_evt[CULL_CMP] : lane_pass[1])));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      zero_irq <= 1'b0;
      cmp_irq  <= '0;
      reload   <= 1'b0;
      cnt_tick <= 1'b0;
    end else begin
      zero_irq <= lane_pass[0];
      cmp_irq  <= cmp_d;
      reload   <= reload_d;
      cnt_tick <= tick;
    end
endmodule

// File: rtl/intr_cull_ctrl_chk.sv
module intr_cull_ctrl_chk #(
  parameter int CMP_N    = 6,
  parameter int CULL_CMP = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             zero_evt,
  input logic [CMP_N-1:0] cmp_evt,
  input logic             xfer_zero_en,
  input logic             xfer_all,
  input logic             zero_irq,
  input logic [CMP_N-1:0] cmp_irq,
  input logic             reload,
  input logic             cnt_tick
);
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!zero_irq && cmp_irq == '0 && !reload && !cnt_tick)); // R1

  AST_ZERO_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && zero_evt) |=> !zero_irq); // R2

  AST_CMP3_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && cmp_evt[CULL_CMP]) |=> !cmp_irq[CULL_CMP]); // R3

  for (genvar i = 0; i < CMP_N; i++) begin : g_plain
    if (i != CULL_CMP) begin : g_chk
      AST_PLAIN_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmp_evt[i]) |=> cmp_irq[i]); // R4
      AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && cmp_evt[i]) |=> !cmp_irq[i]); // R11
    end
  end

  AST_RELOAD_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && (zero_evt || cmp_evt[CULL_CMP])) |=> !reload); // R6

  AST_RELOAD_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_irq && $past(xfer_zero_en && !xfer_all)) |-> reload); // R6

  AST_RELOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && xfer_all && xfer_zero_en && zero_evt) |=> reload); // R7
endmodule

bind intr_cull_ctrl intr_cull_ctrl_chk #(.CMP_N(CMP_N), .CULL_CMP(CULL_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .zero_evt(zero_evt), .cmp_evt(cmp_evt),
  .xfer_zero_en(xfer_zero_en), .xfer_all(xfer_all), .zero_irq(zero_irq),
  .cmp_irq(cmp_irq), .reload(reload), .cnt_tick(cnt_tick));

// File: tb/test_intr_cull_ctrl.sv
`timescale 1ns/1ps
module test_intr_cull_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, zev = 0, xz = 0, x3 = 0, xa = 0;
  logic [5:0] cev = '0;
  logic [2:0] cs = '0, ps = '0;
  logic zero_irq, reload, cnt_tick;
  logic [5:0] cmp_irq;

  always #2.5 clk = ~clk;

  intr_cull_ctrl i_intr_cull_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .zero_evt(zev), .cmp_evt(cev),
    .cull_sel(cs), .pre_sel(ps), .xfer_zero_en(xz), .xfer_cmp_en(x3),
    .xfer_all(xa), .zero_irq(zero_irq), .cmp_irq(cmp_irq), .reload(reload),
    .cnt_tick(cnt_tick));

  int total = 0, bad = 0;
  bit done = 0;
  string phase = "R1";
  logic n_run = 0, n_xz = 0, n_x3 = 0, n_xa = 0;
  logic [2:0] n_cs = '0, n_ps = '0;
  logic [8:0] exp_q[$];
  string tag_q[$];
  int n_zero = 0, n_c3 = 0, n_rl = 0, n_tk = 0;

  int m_cnt[2] = '{0, 0};
  int m_lim[2] = '{0, 0};
  int m_div = 0, m_pre = 0;

  function automatic int lim_of(int c);
    return (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 3 : (c == 3) ? 7 : 15;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic z, input logic [5:0] c);
    logic [8:0] e;
    logic [1:0] ev, pass;
    logic [5:0] ci;
    logic tk, rl;
    @(negedge clk);
    run = n_run; cs = n_cs; ps = n_ps; xz = n_xz; x3 = n_x3; xa = n_xa;
    zev = z; cev = c;
    e = '0;
    if (!run) begin
      m_cnt = '{0, 0};
      m_lim[0] = lim_of(int'(cs));
      m_lim[1] = lim_of(int'(cs));
      m_div = 0;
      if (ps <= 3'd5) m_pre = int'(ps);
    end else begin
      ev = {c[3], z};
      for (int k = 0; k < 2; k++) begin
        pass[k] = ev[k] && (m_cnt[k] == m_lim[k]);
        if (ev[k]) begin
          if (pass[k]) begin m_cnt[k] = 0; m_lim[k] = lim_of(int'(cs)); end
          else m_cnt[k]++;
        end
      end
      tk = m_div >= ((1 << m_pre) - 1);
      m_div = tk ? 0 : m_div + 1;
      if (z && ps <= 3'd5) m_pre = int'(ps);
      ci = c; ci[3] = pass[1];
      rl = (xz && (xa ? z : pass[0])) || (x3 && (xa ? c[3] : pass[1]));
      e = {pass[0], ci, rl, tk};
    end
    exp_q.push_back(e);
    tag_q.push_back(phase);
  endtask

  task automatic idle(input int n);
    n_run = 0;
    repeat (n) step(1'b0, 6'h00);
  endtask

  task automatic clear_counts();
    n_zero = 0; n_c3 = 0; n_rl = 0; n_tk = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [8:0] e, got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {zero_irq, cmp_irq, reload, cnt_tick};
      check(got == e, {t, " (R11 cycle compare)"}, int'(got), int'(e));
      if (zero_irq) n_zero++;
      if (cmp_irq[3]) n_c3++;
      if (reload) n_rl++;
      if (cnt_tick) n_tk++;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({zero_irq, cmp_irq, reload, cnt_tick} == 9'h0, "R1 reset state",
          int'({zero_irq, cmp_irq, reload, cnt_tick}), 0);

    phase = "R1 idle events";
    n_run = 0;
    repeat (6) step(1'b1, 6'h3f);

    for (int c = 0; c < 8; c++) begin
      int n;
      phase = "R2 ratio code";
      n = 1 << ((c > 4) ? 4 : c);
      n_cs = 3'(c);
      idle(2); clear_counts();
      n_run = 1;
      repeat (32) step(1'b1, 6'h08);
      idle(2);
      check(n_zero == 32 / n, "R2 zero pulses per code", n_zero, 32 / n);
      check(n_c3 == 32 / n, "R3 compare-3 pulses per code", n_c3, 32 / n);
    end

    phase = "R3 separate lanes";
    n_cs = 3'd1; idle(2); clear_counts(); n_run = 1;
    step(1'b1, 6'h00); step(1'b0, 6'h08); step(1'b1, 6'h00);
    step(1'b1, 6'h00); step(1'b1, 6'h08); step(1'b1, 6'h00);
    step(1'b1, 6'h00);
    idle(2);
    check(n_zero == 3, "R3 zero count with interleave", n_zero, 3);
    check(n_c3 == 1, "R3 cmp3 count with interleave", n_c3, 1);

    phase = "R4 plain compares";
    n_cs = 3'd4; idle(2); n_run = 1;
    repeat (8) step(1'b0, 6'h37);
    repeat (4) step(1'b0, 6'h05);
    idle(2);

    phase = "R5 mid-run cull change";
    n_cs = 3'd3; idle(2); clear_counts(); n_run = 1;
    repeat (3) step(1'b1, 6'h00);
    n_cs = 3'd0;
    repeat (10) step(1'b1, 6'h00);
    idle(2);
    check(n_zero == 6, "R5 old ratio finishes first", n_zero, 6);

    phase = "R6 reload follows cull";
    n_cs = 3'd1; n_xz = 1; n_x3 = 0; n_xa = 0; idle(2); clear_counts(); n_run = 1;
    repeat (8) step(1'b1, 6'h00);
    idle(2);
    check(n_rl == 4, "R6 zero reload culled", n_rl, 4);
    n_xz = 0; n_x3 = 1; idle(2); clear_counts(); n_run = 1;
    repeat (8) step(1'b1, 6'h08);
    idle(2);
    check(n_rl == 4, "R6 cmp3 reload culled, zero disabled", n_rl, 4);

    phase = "R7 reload on all events";
    n_xz = 1; n_x3 = 0; n_xa = 1; idle(2); clear_counts(); n_run = 1;
    repeat (8) step(1'b1, 6'h08);
    idle(2);
    check(n_rl == 8, "R7 raw reload", n_rl, 8);
    n_xz = 0; n_x3 = 0; n_xa = 0;

    for (int p = 0; p < 6; p++) begin
      phase = "R8 prescaler code";
      n_ps = 3'(p); idle(2); clear_counts(); n_run = 1;
      repeat (64) step(1'b0, 6'h00);
      idle(2);
      check(n_tk == (64 >> p), "R8 tick count", n_tk, 64 >> p);
    end

    phase = "R9 switch at zero event";
    n_cs = 3'd4; n_ps = 3'd0; idle(2); clear_counts(); n_run = 1;
    n_ps = 3'd2;
    repeat (16) step(1'b0, 6'h00);
    step(1'b1, 6'h00);
    repeat (16) step(1'b0, 6'h00);
    idle(2);
    check(n_tk == 21, "R9 ticks across switch", n_tk, 21);
    check(n_zero == 0, "R9 switching event was culled", n_zero, 0);

    phase = "R10 prohibited code";
    n_ps = 3'd3; idle(2); n_ps = 3'd6; idle(2); clear_counts(); n_run = 1;
    repeat (32) step(1'b0, 6'h00);
    n_ps = 3'd7;
    step(1'b1, 6'h00);
    repeat (31) step(1'b0, 6'h00);
    idle(2);
    check(n_tk == 8, "R10 ratio held", n_tk, 8);

    phase = "R11 random";
    lfsr = 16'hace1;
    n_run = 1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) n_cs = lfsr[6:4];
      if (lfsr[3:0] == 4'h1) n_ps = lfsr[9:7];
      if (lfsr[3:0] == 4'h2) {n_xz, n_x3, n_xa} = lfsr[12:10];
      n_run = (lfsr[7:0] != 8'h55);
      step(lfsr[11], lfsr[15:10]);
    end
    idle(3);
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule